// File: doc/BRIEF.md
# Trap Entry Value Capture

This block records the machine trap state at the moment a trap is taken. It receives a one-cycle trap strobe together with a 32-bit request word, the program counter of the faulting instruction, the raw instruction bits and a jump or branch destination that the execute stage computed. On an accepted strobe it loads three registers in the same clock edge: the exception PC, the cause, and the trap value.

The trap value depends on the cause. A misaligned instruction fetch stores the destination that could not be fetched. It stores neither the PC nor the instruction. An illegal instruction stores the instruction word. When the core supports 16-bit encodings and the word is one of them, only its lower half is stored. All other causes store zero. Which input feeds the trap value path is chosen from the low byte of the cause field. Vectoring, interrupts, debug entry and privilege stacking belong to other blocks.

Top module: `trap_entry_capture`

## Requirements
- R1: After the asynchronous reset is released, `epc_o`, `cause_o` and `tval_o` are all zero.
- R2: The registers load only on a clock edge where `trap_i` is high and `flags_i[31]` (the active bit) is 1. On any other edge they hold their values. This includes a strobe whose active bit is 0, and an active bit without a strobe.
- R3: On an accepted trap, `epc_o` takes `pc_i`.
- R4: On an accepted trap, `cause_o` takes the cause field `flags_i[30:16]`, zero-extended, so bit 31 is 0. The trap id `flags_i[15:0]` has no effect on any output.
- R5: Cause field 0 (misaligned fetch) sets `tval_o` to `target_i`.
- R6: Cause field 2 (illegal instruction) with `cmp_en_i` = 0 sets `tval_o` to the full `instr_i`.
- R7: Cause field 2 with `cmp_en_i` = 1 and `instr_i[1:0]` = 2'b11 sets `tval_o` to the full `instr_i`.
- R8: Cause field 2 with `cmp_en_i` = 1 and `instr_i[1:0]` not 2'b11 sets `tval_o` to `instr_i[15:0]`, zero-extended.
- R9: Any cause field other than 0 or 2 sets `tval_o` to zero. This includes values such as 0x100 and 0x102, whose low byte is 0 or 2.
- R10: All three registers are written on the same clock edge. A value appears at the outputs on the edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trap_i | input | 1 | One-cycle trap strobe |
| flags_i | input | 32 | Request word: active bit 31, cause 30:16, trap id 15:0 |
| pc_i | input | XLEN | PC of the faulting instruction |
| instr_i | input | 32 | Instruction bits of the faulting instruction |
| target_i | input | XLEN | Computed jump or branch destination |
| cmp_en_i | input | 1 | 16-bit instruction support enabled |
| epc_o | output | XLEN | Registered exception PC |
| cause_o | output | XLEN | Registered cause |
| tval_o | output | XLEN | Registered trap value |

## Verification
The hardest case to reach is a cause field whose low byte matches a real cause while its upper bits do not. An example is 0x100, which routes the destination address into the value path even though the trap is not a misaligned fetch. A plain sweep of real cause codes never produces this. The driver therefore builds request words with bits 30:24 set by hand and checks that zero is stored. Strobes with a cleared active bit are placed between accepted traps, so that any spurious load shows up as a changed held value.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int FLAGS_W   = 32;
  localparam int ACT_BIT   = 31;
  localparam int CAUSE_LSB = 16;
  localparam int CAUSE_W   = 15;
  localparam int SEL_W     = 8;
  localparam int ID_W      = 16;
  localparam int ILEN      = 32;
  localparam int CLEN      = 16;

  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = CAUSE_W'(0);
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = CAUSE_W'(2);

  typedef struct packed {
    logic               active;
    logic [CAUSE_W-1:0] cause;
    logic [ID_W-1:0]    id;
  } trap_req_t;
endpackage

// File: rtl/trap_req_decode.sv
module trap_req_decode
  import trap_pkg::*;
(
  input  logic [FLAGS_W-1:0] flags_i,
  input  logic               trap_i,
  output logic               take_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [SEL_W-1:0]   sel_o
);
  trap_req_t req;

  always_comb begin
    req     = trap_req_t'(flags_i);
    take_o  = trap_i & req.active;
    cause_o = req.cause;
    // source select looks at the low byte of the cause field only
    sel_o   = req.cause[SEL_W-1:0];
  end
endmodule

// File: rtl/trap_tval_sel.sv
module trap_tval_sel
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [ILEN-1:0]    instr_i,
  input  logic [XLEN-1:0]    target_i,
  input  logic               cmp_en_i,
  output logic [XLEN-1:0]    tval_o
);
  logic [XLEN-1:0] src;
  logic            full_len;

  always_comb begin
    src      = (sel_i == '0) ? target_i : XLEN'(instr_i);
    full_len = !cmp_en_i || (src[1:0] == 2'b11);
    unique case (cause_i)
      CAUSE_MISALIGN: tval_o = src;
      CAUSE_ILLEGAL:  tval_o = full_len ? src : XLEN'(src[CLEN-1:0]);
      default:        tval_o = '0;
    endcase
  end
endmodule

// File: rtl/trap_csr_regs.sv
module trap_csr_regs #(
  parameter int XLEN = 32,
  parameter int NREG = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [NREG-1:0][XLEN-1:0] d_i,
  output logic [NREG-1:0][XLEN-1:0] q_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q_o[g] <= '0;
      else if (we_i) q_o[g] <= d_i[g];
    end
  end
endmodule

// File: rtl/trap_entry_capture.sv
module trap_entry_capture
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 trap_i,
  input  logic [FLAGS_W-1:0]   flags_i,
  input  logic [XLEN-1:0]      pc_i,
  input  logic [ILEN-1:0]      instr_i,
  input  logic [XLEN-1:0]      target_i,
  input  logic                 cmp_en_i,
  output logic [XLEN-1:0]      epc_o,
  output logic [XLEN-1:0]      cause_o,
  output logic [XLEN-1:0]      tval_o
);
  localparam int NREG  = 3;
  localparam int R_EPC = 0;
  localparam int R_CAU = 1;
  localparam int R_TVL = 2;

  logic                      take;
  logic [CAUSE_W-1:0]        cause;
  logic [SEL_W-1:0]          sel;
  logic [XLEN-1:0]           tval_d;
  logic [NREG-1:0][XLEN-1:0] d, q;

  trap_req_decode u_dec (
    .flags_i (flags_i),
    .trap_i  (trap_i),
    .take_o  (take),
    .cause_o (cause),
    .sel_o   (sel)
  );

  trap_tval_sel #(.XLEN(XLEN)) u_sel (
    .cause_i  (cause),
    .sel_i    (sel),
    .instr_i  (instr_i),
    .target_i (target_i),
    .cmp_en_i (cmp_en_i),
    .tval_o   (tval_d)
  );

  always_comb begin
    d[R_EPC] = pc_i;
    d[R_CAU] = XLEN'(cause);
    d[R_TVL] = tval_d;
  end

  trap_csr_regs #(.XLEN(XLEN), .NREG(NREG)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (take),
    .d_i    (d),
    .q_o    (q)
  );

  assign epc_o   = q[R_EPC];
  assign cause_o = q[R_CAU];
  assign tval_o  = q[R_TVL];

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trap_i && flags_i[ACT_BIT]) |=> $stable(epc_o) && $stable(cause_o) && $stable(tval_o));
  // R3
  epc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i && flags_i[ACT_BIT]) |=> epc_o == $past(pc_i));
  // R4
  cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i && flags_i[ACT_BIT]) |=> cause_o == XLEN'($past(flags_i[30:16])));
  // R5
  misalign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i && flags_i[ACT_BIT] && flags_i[30:16] == '0) |=> tval_o == $past(target_i));
  // R9
  other_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i && flags_i[ACT_BIT] && flags_i[30:16] != 15'd0 && flags_i[30:16] != 15'd2)
      |=> tval_o == '0);
  // R8
  short_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i && flags_i[ACT_BIT] && flags_i[30:16] == 15'd2 && cmp_en_i && instr_i[1:0] != 2'b11)
      |=> tval_o[XLEN-1:CLEN] == '0);
endmodule

// File: tb/sim_trap_entry_capture.sv
module sim_trap_entry_capture;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            trap_i = 1'b0;
  logic [31:0]     flags_i = '0;
  logic [XLEN-1:0] pc_i = '0;
  logic [31:0]     instr_i = '0;
  logic [XLEN-1:0] target_i = '0;
  logic            cmp_en_i = 1'b0;
  logic [XLEN-1:0] epc_o, cause_o, tval_o;

  always #4 clk = ~clk;

  trap_entry_capture #(.XLEN(XLEN)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .trap_i(trap_i), .flags_i(flags_i),
    .pc_i(pc_i), .instr_i(instr_i), .target_i(target_i), .cmp_en_i(cmp_en_i),
    .epc_o(epc_o), .cause_o(cause_o), .tval_o(tval_o)
  );

  typedef struct {
    logic [XLEN-1:0] epc;
    logic [XLEN-1:0] cau;
    logic [XLEN-1:0] tvl;
    string           tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  logic [XLEN-1:0] m_epc = '0, m_cau = '0, m_tvl = '0;
  bit mon_on = 0;

  function automatic logic [XLEN-1:0] model_tval(logic [31:0] f, logic [31:0] ins,
                                                 logic [XLEN-1:0] tgt, logic ce);
    logic [14:0] c = f[30:16];
    if (c == 15'd0) return tgt;
    if (c == 15'd2) begin
      if (!ce || ins[1:0] == 2'b11) return XLEN'(ins);
      return XLEN'(ins[15:0]);
    end
    return '0;
  endfunction

  task automatic drive(input bit stb, input logic [31:0] f, input logic [XLEN-1:0] pc,
                       input logic [31:0] ins, input logic [XLEN-1:0] tgt,
                       input bit ce, input string tag);
    exp_t e;
    @(negedge clk);
    trap_i = stb; flags_i = f; pc_i = pc; instr_i = ins; target_i = tgt; cmp_en_i = ce;
    if (stb && f[31]) begin
      m_epc = pc;
      m_cau = XLEN'(f[30:16]);
      m_tvl = model_tval(f, ins, tgt, ce);
    end
    e.epc = m_epc; e.cau = m_cau; e.tvl = m_tvl; e.tag = tag;
    q.push_back(e);
  endtask

  function automatic logic [31:0] req(input bit act, input logic [14:0] c, input logic [15:0] id);
    return {act, c, id};
  endfunction

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (mon_on && q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (epc_o !== e.epc || cause_o !== e.cau || tval_o !== e.tvl) begin
          failures++;
          $display("FAIL %s: epc=%h cause=%h tval=%h expected epc=%h cause=%h tval=%h",
                   e.tag, epc_o, cause_o, tval_o, e.epc, e.cau, e.tvl);
        end
      end
    end
  end

  initial begin : watchdog
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    checks++;
    if (epc_o !== '0 || cause_o !== '0 || tval_o !== '0) begin
      failures++;
      $display("FAIL R1: epc=%h cause=%h tval=%h expected all zero", epc_o, cause_o, tval_o);
    end
    mon_on = 1;
    // R5 R3 R4 R10: misaligned fetch records destination
    drive(1, req(1, 15'd0, 16'h0000), 32'h0000_1000, 32'h0040_006f, 32'h0000_1402, 0, "R5 misalign");
    drive(1, req(1, 15'd0, 16'h00ff), 32'h8000_0010, 32'hfe00_0ee3, 32'h7fff_fffe, 1, "R5 misalign neg offset");
    // R2: strobe with active bit clear, then active bit without strobe
    drive(1, req(0, 15'd2, 16'h0001), 32'hdead_beef, 32'h1234_5678, 32'h0, 0, "R2 inactive strobe");
    drive(0, req(1, 15'd5, 16'h0000), 32'hcafe_0000, 32'h1111_1111, 32'h2, 0, "R2 no strobe");
    // R6: illegal, 16-bit support off, short pattern kept in full
    drive(1, req(1, 15'd2, 16'h0000), 32'h0000_2000, 32'habcd_0001, 32'h5, 0, "R6 illegal full");
    // R7: illegal, support on, 32-bit encoding
    drive(1, req(1, 15'd2, 16'h0000), 32'h0000_2004, 32'hffff_ffff, 32'h5, 1, "R7 illegal long");
    // R8: illegal, support on, 16-bit encodings
    drive(1, req(1, 15'd2, 16'h0000), 32'h0000_2008, 32'h9876_4321, 32'h5, 1, "R8 illegal short 01");
    drive(1, req(1, 15'd2, 16'h0000), 32'h0000_200a, 32'hffff_fffc, 32'h5, 1, "R8 illegal short 00");
    drive(1, req(1, 15'd2, 16'h0000), 32'h0000_200c, 32'h5555_aaaa, 32'h5, 1, "R8 illegal short 10");
    // R9: other causes store zero
    drive(1, req(1, 15'd5, 16'h0003), 32'h0000_3000, 32'hffff_ffff, 32'hffff_ffff, 1, "R9 cause 5");
    drive(1, req(1, 15'h0100, 16'h0000), 32'h0000_3004, 32'h1234_5677, 32'h0000_0abc, 0, "R9 cause 0x100");
    drive(1, req(1, 15'h0102, 16'h0000), 32'h0000_3008, 32'h1234_5677, 32'h0000_0abc, 1, "R9 cause 0x102");
    drive(1, req(1, 15'h7fff, 16'hffff), 32'h0000_300c, 32'h1234_5677, 32'h0000_0abc, 1, "R9 cause max");
    // R4: trap id ignored
    drive(1, req(1, 15'd0, 16'hbeef), 32'h0000_4000, 32'h0, 32'h0000_4001, 0, "R4 trap id ignored");
    drive(0, req(0, 15'd0, 16'h0000), 32'h0, 32'h0, 32'h0, 0, "R2 idle hold");
    // back-to-back mixed traffic
    for (int i = 0; i < 40; i++) begin
      logic [14:0] c;
      c = (i % 4 == 0) ? 15'd0 : (i % 4 == 1) ? 15'd2 : 15'(i);
      drive(i % 5 != 4, req(i % 7 != 6, c, 16'(i * 37)), $urandom, $urandom, $urandom,
            i % 2, "R10 mixed");
    end
    drive(0, req(0, 15'd0, 16'h0), 32'h0, 32'h0, 32'h0, 0, "R2 final hold");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule